// File: doc/BRIEF.md
# Bit Manipulation Unit with Carry Logic

This block carries out one bit-level operation on a byte operand per accepted request. It can force a chosen bit to one or zero, flip it, or test it. It can also combine the carry flag with the chosen bit, or with that bit inverted, through AND, OR or XOR. It can copy the bit, or its complement, into the carry flag. It can write the carry flag, or its complement, into the bit. The caller supplies the operand byte, the bit position, an operation code and the current carry and zero flags. One cycle later the unit returns the resulting byte, a write-back enable and both flags.

The bit position comes from a 3-bit immediate field. For set, clear, flip and test, the caller may instead select the low bits of a register operand. The carry-logic, load and store forms always take the position from the immediate. Effective address generation and any memory read-modify-write sequencing belong to the surrounding pipeline. The write-back enable tells that pipeline whether the byte has to be stored back.

Operation codes (4 bits): 0 set, 1 clear, 2 flip, 3 test, 4 C AND bit, 5 C AND not-bit, 6 C OR bit, 7 C OR not-bit, 8 C XOR bit, 9 C XOR not-bit, 10 load bit, 11 load not-bit, 12 store C, 13 store not-C, 14 and 15 reserved.

Top module: `bmu_top`

## Requirements
- R1: While reset is held and after it is released with no request, resByte, wrEn, newC, newZ and resValid are all 0.
- R2: A request accepted with inValid high at a clock edge raises resValid after that edge, and only then. resValid is low after an edge where inValid was low.
- R3: Set (0), clear (1) and flip (2) return the operand with only the selected bit forced to 1, forced to 0 or inverted. They assert wrEn and return newC = cIn and newZ = zIn.
- R4: Test (3) returns newZ equal to the inverse of the selected bit. It returns the operand unchanged, wrEn = 0 and newC = cIn.
- R5: For codes 0 to 3 the bit position is bitReg[2:0] when useReg is 1, and bitImm when useReg is 0.
- R6: For codes 4 to 13 the bit position is always bitImm, whatever useReg and bitReg hold.
- R7: Codes 4/6/8 set newC to cIn AND/OR/XOR the selected bit. Codes 5/7/9 use the inverse of that bit. The byte is returned unchanged with wrEn = 0 and newZ = zIn.
- R8: Load (10) sets newC to the selected bit and load-inverse (11) sets it to the bit's inverse. The byte is unchanged, wrEn = 0 and newZ = zIn.
- R9: Store (12) writes cIn and store-inverse (13) writes NOT cIn into the selected bit. Every other bit is kept, wrEn = 1, and both flags pass through.
- R10: Reserved codes 14 and 15 return the operand unchanged, wrEn = 0, newC = cIn and newZ = zIn.
- R11: wrEn is 1 for codes 0, 1, 2, 12 and 13 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe |
| opCode | input | 4 | Operation code |
| operand | input | 8 | Byte operand |
| bitImm | input | 3 | Immediate bit position |
| bitReg | input | 8 | Register supplying a bit position in its low bits |
| useReg | input | 1 | Take the position from bitReg (codes 0 to 3 only) |
| cIn | input | 1 | Current carry flag |
| zIn | input | 1 | Current zero flag |
| resValid | output | 1 | Result valid |
| resByte | output | 8 | Resulting byte |
| wrEn | output | 1 | Byte must be written back |
| newC | output | 1 | Resulting carry flag |
| newZ | output | 1 | Resulting zero flag |

## Verification
The bench builds the unit with its default byte width of 8, so the position field is 3 bits wide. Every one of the eight bit positions can then be visited for each operation code. Sweeping the positions with both carry values and a patterned operand covers every case where the selected bit and the carry disagree. Mismatched immediate and register positions show which source each code obeys.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [3:0] {
    OP_SET    = 4'd0,
    OP_CLR    = 4'd1,
    OP_FLIP   = 4'd2,
    OP_TEST   = 4'd3,
    OP_AND    = 4'd4,
    OP_ANDN   = 4'd5,
    OP_OR     = 4'd6,
    OP_ORN    = 4'd7,
    OP_XOR    = 4'd8,
    OP_XORN   = 4'd9,
    OP_LOAD   = 4'd10,
    OP_LOADN  = 4'd11,
    OP_STORE  = 4'd12,
    OP_STOREN = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } bmuOp_e;

  // value written into the selected bit
  typedef enum logic [1:0] {
    BIT_ONE   = 2'd0,
    BIT_ZERO  = 2'd1,
    BIT_FLIP  = 2'd2,
    BIT_CARRY = 2'd3
  } bitSrc_e;

  // how the carry result is formed
  typedef enum logic [2:0] {
    CF_HOLD = 3'd0,
    CF_AND  = 3'd1,
    CF_OR   = 3'd2,
    CF_XOR  = 3'd3,
    CF_LOAD = 3'd4
  } carryFn_e;

  typedef struct packed {
    logic     regIndex;   // register may supply the position
    logic     invOperand; // use inverse of the selected bit
    logic     writeBit;   // selected bit is replaced
    bitSrc_e  bitSrc;
    logic     invCarry;   // store the inverse of carry
    carryFn_e carryFn;
    logic     updZ;       // zero flag takes inverse of the bit
  } bmuStrobe_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic [3:0]  opCode,
  output bmuStrobe_t  stb
);

  bmuOp_e op;
  assign op = bmuOp_e'(opCode);

  always_comb begin
    stb = '{regIndex: 1'b0, invOperand: 1'b0, writeBit: 1'b0,
            bitSrc: BIT_ONE, invCarry: 1'b0, carryFn: CF_HOLD, updZ: 1'b0};
    case (op)
      OP_SET: begin
        stb.regIndex = 1'b1;
        stb.writeBit = 1'b1;
        stb.bitSrc   = BIT_ONE;
      end
      OP_CLR: begin
        stb.regIndex = 1'b1;
        stb.writeBit = 1'b1;
        stb.bitSrc   = BIT_ZERO;
      end
      OP_FLIP: begin
        stb.regIndex = 1'b1;
        stb.writeBit = 1'b1;
        stb.bitSrc   = BIT_FLIP;
      end
      OP_TEST: begin
        stb.regIndex = 1'b1;
        stb.updZ     = 1'b1;
      end
      OP_AND:  stb.carryFn = CF_AND;
      OP_ANDN: begin
        stb.carryFn    = CF_AND;
        stb.invOperand = 1'b1;
      end
      OP_OR:   stb.carryFn = CF_OR;
      OP_ORN: begin
        stb.carryFn    = CF_OR;
        stb.invOperand = 1'b1;
      end
      OP_XOR:  stb.carryFn = CF_XOR;
      OP_XORN: begin
        stb.carryFn    = CF_XOR;
        stb.invOperand = 1'b1;
      end
      OP_LOAD: stb.carryFn = CF_LOAD;
      OP_LOADN: begin
        stb.carryFn    = CF_LOAD;
        stb.invOperand = 1'b1;
      end
      OP_STORE: begin
        stb.writeBit = 1'b1;
        stb.bitSrc   = BIT_CARRY;
      end
      OP_STOREN: begin
        stb.writeBit = 1'b1;
        stb.bitSrc   = BIT_CARRY;
        stb.invCarry = 1'b1;
      end
      default: ; // reserved codes: pass everything through
    endcase
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  bmuStrobe_t        stb,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bitImm,
  input  logic [DATA_W-1:0] bitReg,
  input  logic              useReg,
  input  logic              cIn,
  input  logic              zIn,
  output logic              resValid,
  output logic [DATA_W-1:0] resByte,
  output logic              wrEn,
  output logic              newC,
  output logic              newZ
);

  logic [IDX_W-1:0]  bitIdx;
  logic              selBit;
  logic              opBit;
  logic              newBitVal;
  logic              nextC;
  logic              nextZ;
  logic [DATA_W-1:0] nextByte;

  assign bitIdx = (stb.regIndex && useReg) ? bitReg[IDX_W-1:0] : bitImm;
  assign selBit = operand[bitIdx];
  assign opBit  = selBit ^ stb.invOperand;

  always_comb begin
    case (stb.carryFn)
      CF_AND:  nextC = cIn & opBit;
      CF_OR:   nextC = cIn | opBit;
      CF_XOR:  nextC = cIn ^ opBit;
      CF_LOAD: nextC = opBit;
      default: nextC = cIn;
    endcase
  end

  always_comb begin
    case (stb.bitSrc)
      BIT_ONE:   newBitVal = 1'b1;
      BIT_ZERO:  newBitVal = 1'b0;
      BIT_FLIP:  newBitVal = ~selBit;
      default:   newBitVal = cIn ^ stb.invCarry;
    endcase
  end

  assign nextZ = stb.updZ ? ~selBit : zIn;

  for (genvar g = 0; g < DATA_W; g++) begin : gBitLane
    localparam logic [IDX_W-1:0] LANE = IDX_W'(g);
    assign nextByte[g] = (stb.writeBit && (bitIdx == LANE)) ? newBitVal : operand[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resByte  <= '0;
      wrEn     <= 1'b0;
      newC     <= 1'b0;
      newZ     <= 1'b0;
    end else begin
      resValid <= inValid;
      wrEn     <= inValid & stb.writeBit;
      if (inValid) begin
        resByte <= nextByte;
        newC    <= nextC;
        newZ    <= nextZ;
      end
    end
  end

endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bitImm,
  input  logic [DATA_W-1:0] bitReg,
  input  logic              useReg,
  input  logic              cIn,
  input  logic              zIn,
  output logic              resValid,
  output logic [DATA_W-1:0] resByte,
  output logic              wrEn,
  output logic              newC,
  output logic              newZ
);

  bmuStrobe_t stb;

  bmu_ctrl uCtrl (
    .opCode (opCode),
    .stb    (stb)
  );

  bmu_datapath #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .operand  (operand),
    .bitImm   (bitImm),
    .bitReg   (bitReg),
    .useReg   (useReg),
    .cIn      (cIn),
    .zIn      (zIn),
    .resValid (resValid),
    .resByte  (resByte),
    .wrEn     (wrEn),
    .newC     (newC),
    .newZ     (newZ)
  );

endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] operand,
  input logic [IDX_W-1:0]  bitImm,
  input logic              cIn,
  input logic              zIn,
  input logic              resValid,
  input logic [DATA_W-1:0] resByte,
  input logic              wrEn,
  input logic              newC,
  input logic              newZ
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resValid && !wrEn));

  assert_one_bit_touched_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode <= 4'd2) |=> ($countones(resByte ^ $past(operand)) <= 1 && wrEn));

  assert_test_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd3) |=> (!wrEn && newC == $past(cIn) && resByte == $past(operand)));

  assert_carry_forms_keep_z_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode >= 4'd4 && opCode <= 4'd11) |=> (!wrEn && newZ == $past(zIn)));

  assert_store_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd12) |=> (resByte[$past(bitImm)] == $past(cIn) && wrEn));

  assert_reserved_inert_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode >= 4'd14) |=>
      (!wrEn && newC == $past(cIn) && newZ == $past(zIn) && resByte == $past(operand)));

endmodule

bind bmu_top bmu_checker #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .operand  (operand),
  .bitImm   (bitImm),
  .cIn      (cIn),
  .zIn      (zIn),
  .resValid (resValid),
  .resByte  (resByte),
  .wrEn     (wrEn),
  .newC     (newC),
  .newZ     (newZ)
);

// File: tb/tb_bmu_top.sv
`timescale 1ns/1ps
module tb_bmu_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] operand = '0;
  logic [2:0] bitImm = '0;
  logic [7:0] bitReg = '0;
  logic       useReg = 1'b0;
  logic       cIn = 1'b0;
  logic       zIn = 1'b0;
  logic       resValid;
  logic [7:0] resByte;
  logic       wrEn;
  logic       newC;
  logic       newZ;

  always #2 clk = ~clk;

  bmu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .operand(operand), .bitImm(bitImm), .bitReg(bitReg), .useReg(useReg),
    .cIn(cIn), .zIn(zIn), .resValid(resValid), .resByte(resByte),
    .wrEn(wrEn), .newC(newC), .newZ(newZ)
  );

  typedef struct packed {
    logic [7:0] byteV;
    logic       wr;
    logic       c;
    logic       z;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;

  // Expected result derived from the requirement list.
  function automatic exp_t model(input logic [3:0] op, input logic [7:0] d,
                                 input logic [2:0] imm, input logic [7:0] rg,
                                 input logic ur, input logic c, input logic z);
    exp_t e;
    int   pos;
    pos = (op <= 4'd3 && ur) ? int'(rg[2:0]) : int'(imm); // R5, R6
    e.byteV = d; e.wr = 1'b0; e.c = c; e.z = z;
    case (op)
      4'd0:  begin e.byteV[pos] = 1'b1;     e.wr = 1'b1; end // R3, R11
      4'd1:  begin e.byteV[pos] = 1'b0;     e.wr = 1'b1; end
      4'd2:  begin e.byteV[pos] = ~d[pos];  e.wr = 1'b1; end
      4'd3:  e.z = ~d[pos];                                  // R4
      4'd4:  e.c = c &  d[pos];                              // R7
      4'd5:  e.c = c & ~d[pos];
      4'd6:  e.c = c |  d[pos];
      4'd7:  e.c = c | ~d[pos];
      4'd8:  e.c = c ^  d[pos];
      4'd9:  e.c = c ^ ~d[pos];
      4'd10: e.c = d[pos];                                   // R8
      4'd11: e.c = ~d[pos];
      4'd12: begin e.byteV[pos] = c;  e.wr = 1'b1; end      // R9
      4'd13: begin e.byteV[pos] = ~c; e.wr = 1'b1; end
      default: ;                                             // R10
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] d, input logic [2:0] imm,
                       input logic [7:0] rg, input logic ur, input logic c,
                       input logic z, input string tag);
    @(negedge clk);
    inValid = 1'b1; opCode = op; operand = d; bitImm = imm;
    bitReg = rg; useReg = ur; cIn = c; zIn = z;
    expQ.push_back(model(op, d, imm, rg, ur, c, z));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opCode = 4'($urandom_range(15));
      operand = 8'($urandom);
    end
  endtask

  // Monitor: compares each result against the oldest queued expectation.
  always @(negedge clk) begin
    if (rstN && resValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2: resValid=1 actual, expected no result pending");
      end else begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({resByte, wrEn, newC, newZ} !== {e.byteV, e.wr, e.c, e.z}) begin
          errors++;
          $display("FAIL %s: actual byte=%h wr=%b c=%b z=%b expected byte=%h wr=%b c=%b z=%b",
                   t, resByte, wrEn, newC, newZ, e.byteV, e.wr, e.c, e.z);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 during reset
    if ({resValid, resByte, wrEn, newC, newZ} !== 12'h0) begin
      errors++;
      $display("FAIL R1: actual %h expected 000", {resValid, resByte, wrEn, newC, newZ});
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++; // R1 after release with no request
    if ({resValid, resByte, wrEn, newC, newZ} !== 12'h0) begin
      errors++;
      $display("FAIL R1: actual %h expected 000", {resValid, resByte, wrEn, newC, newZ});
    end

    // R3 / R11: set, clear, flip at every position
    for (int b = 0; b < 8; b++) begin
      drive(4'd0, 8'h00, 3'(b), 8'h00, 1'b0, 1'b1, 1'b0, "R3/R11 set");
      drive(4'd1, 8'hFF, 3'(b), 8'h00, 1'b0, 1'b0, 1'b1, "R3/R11 clear");
      drive(4'd2, 8'hA5, 3'(b), 8'h00, 1'b0, 1'b1, 1'b1, "R3/R11 flip");
    end
    idle(2);
    // R4: test on a pattern
    for (int b = 0; b < 8; b++)
      drive(4'd3, 8'h5A, 3'(b), 8'h00, 1'b0, b[0], ~b[1], "R4 test");
    // R5: register-supplied position differs from immediate
    for (int b = 0; b < 8; b++) begin
      drive(4'd0, 8'h00, 3'(~b), 8'hF8 | 8'(b), 1'b1, 1'b0, 1'b0, "R5 set reg");
      drive(4'd2, 8'h3C, 3'(~b), 8'hA8 | 8'(b), 1'b1, 1'b0, 1'b0, "R5 flip reg");
      drive(4'd3, 8'h96, 3'(~b), 8'h00 | 8'(b), 1'b1, 1'b1, 1'b1, "R5 test reg");
    end
    idle(3);
    // R6: carry forms ignore useReg and bitReg
    for (int b = 0; b < 8; b++) begin
      drive(4'd4, 8'h0F, 3'(b), 8'(7 - b), 1'b1, 1'b1, 1'b0, "R6 and imm");
      drive(4'd12, 8'hF0, 3'(b), 8'(7 - b), 1'b1, 1'b1, 1'b0, "R6 store imm");
    end
    // R7: logic forms, both carry values, every position
    for (int op = 4; op <= 9; op++)
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 8; b++)
          drive(4'(op), 8'h3C, 3'(b), 8'h00, 1'b0, c[0], b[0], "R7 carry logic");
    idle(1);
    // R8: loads
    for (int op = 10; op <= 11; op++)
      for (int b = 0; b < 8; b++)
        drive(4'(op), 8'hC6, 3'(b), 8'h00, 1'b0, ~b[0], b[1], "R8 load");
    // R9: stores with both carry values on patterns
    for (int op = 12; op <= 13; op++)
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 8; b++)
          drive(4'(op), c[0] ? 8'h55 : 8'hAA, 3'(b), 8'h00, 1'b0, c[0], 1'b1, "R9/R11 store");
    // R10: reserved codes
    for (int op = 14; op <= 15; op++)
      for (int c = 0; c < 2; c++)
        drive(4'(op), 8'h69, 3'(c * 5), 8'hFF, 1'b1, c[0], ~c[0], "R10 reserved");
    idle(4);

    checks++; // R2: every request produced exactly one result
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d results missing, expected 0", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule